// File: doc/BRIEF.md
# I2C Bus Activity and Timeout Monitor

This block listens passively to the two wires of an I2C bus and reports what it sees to the logic around it. It never drives the bus. Each wire first goes through a two-flop synchronizer and then a glitch filter, so that short spikes are rejected. From the filtered levels the block detects START (including repeated START) and STOP conditions, and it keeps a level that shows whether a transaction is in progress.

The block also measures how long the filtered clock wire has been held low, counted in system clocks. It raises a one-cycle pulse when that time goes beyond a programmable limit, which marks a stuck or stretched bus. A host controller uses the pulses as event flags and the busy level to decide whether it may start a transfer. A single enable input turns all detection off. While the enable is low, the busy level is cleared.

Top module: `i2c_bus_monitor`

## Requirements
- R1: Both `sda_in` and `scl_in` pass through two synchronizer flops and then a filter. A filtered level takes a new value only after the synchronized line has differed from it on `FILT_CYC` consecutive clock edges (default 3). A spike shorter than that never reaches the filtered level.
- R2: `scl_level` is the filtered clock line: 1 while SCL is high and 0 while SCL is low. A change that is held on `scl_in` reaches `scl_level` 2 + `FILT_CYC` clock edges after it is first sampled.
- R3: A START is filtered SDA falling while filtered SCL is high in both the current and the previous cycle. A START produces `start_pulse` high for exactly one cycle, one clock after the filtered edge. A repeated START is detected in the same way.
- R4: A STOP is filtered SDA rising while filtered SCL is high in both the current and the previous cycle. A STOP produces `stop_pulse` high for exactly one cycle, one clock after the filtered edge.
- R5: `bus_busy` becomes 1 in the same cycle that `start_pulse` is asserted.
- R6: `bus_busy` becomes 0 in the same cycle that `stop_pulse` is asserted.
- R7: While `enable` is 0, the following are all 0 from the next clock edge onward: `bus_busy`, `start_pulse`, `stop_pulse` and `timeout_pulse`. When `enable` falls in the cycle in which a condition is detected, the enable takes priority.
- R8: The block counts the clock edges on which filtered SCL is low. When filtered SCL has been low on `timeout_limit` + 1 consecutive edges, `timeout_pulse` is asserted for one cycle.
- R9: `timeout_pulse` fires at most once for each low period of SCL. The low-time count clears whenever filtered SCL is high, so the next low period is timed afresh.
- R10: A `timeout_limit` of 0 disables the timeout, so `timeout_pulse` stays 0.
- R11: While `rst_n` is 0 (synchronous, active low), the outputs take these values: `start_pulse`, `stop_pulse`, `bus_busy` and `timeout_pulse` are 0, and `scl_level` is 1 (idle bus).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Module enable; 0 suppresses detection and clears busy |
| timeout_limit | input | 16 | SCL low-time limit in clocks; 0 disables the timeout |
| sda_in | input | 1 | Raw SDA wire level (asynchronous) |
| scl_in | input | 1 | Raw SCL wire level (asynchronous) |
| start_pulse | output | 1 | One-cycle pulse on START or repeated START |
| stop_pulse | output | 1 | One-cycle pulse on STOP |
| scl_level | output | 1 | Filtered SCL level |
| bus_busy | output | 1 | 1 between a START and the following STOP |
| timeout_pulse | output | 1 | One-cycle pulse when SCL low time exceeds the limit |

## Verification
The enable and the condition detector can act in the same cycle. If the enable falls on the very edge at which a STOP or START pulse would register, the enable must win: no pulse appears and busy drops.

To provoke this, the bench releases SDA into a STOP. It then lowers the enable after each of a range of delays, so that the sweep passes through the exact registering edge. A behavioural cycle model in the bench judges every output on every clock. The bench also makes directed tallies of pulses per low period and per glitch.

// File: rtl/i2cmon_pkg.sv
// Package: shared definitions for the I2C bus monitor.
// Assumes: the raw bus wires idle high and are asynchronous to clk.
package i2cmon_pkg;
    // Index of each bus wire inside the conditioned line vector
    localparam int LINE_SDA = 0;
    localparam int LINE_SCL = 1;
    localparam int NUM_LINES = 2;

    // Filtered bus level pair
    typedef struct packed {
        logic scl;
        logic sda;
    } bus_lines_t;
endpackage

// File: rtl/i2cmon_line_filter.sv
// Module: two-flop synchronizer followed by a consecutive-sample glitch filter.
// The output level follows the synchronized input only after the input has
// disagreed with it on FILT_CYC consecutive edges.
// Assumes: FILT_CYC >= 1; the line idles at RESET_VAL.
module i2cmon_line_filter #(
    parameter int   FILT_CYC  = 3,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic level
);
    localparam int CNTW = $clog2(FILT_CYC) + 1;

    logic [1:0]      sync_q;
    logic [CNTW-1:0] agree_cnt;

    // Two-stage synchronizer for the asynchronous wire
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= {2{RESET_VAL}};
        else        sync_q <= {sync_q[0], raw};
    end

    // Accept a new level after FILT_CYC consecutive disagreeing samples
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level     <= RESET_VAL;
            agree_cnt <= '0;
        end else if (sync_q[1] == level) begin
            agree_cnt <= '0;
        end else if (agree_cnt == CNTW'(FILT_CYC - 1)) begin
            level     <= sync_q[1];
            agree_cnt <= '0;
        end else begin
            agree_cnt <= agree_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/i2cmon_cond_detect.sv
// Module: START / STOP condition detector and bus-busy tracker.
// A condition needs SCL high in both the current and the previous cycle, with
// an SDA edge between those cycles. Enable low suppresses pulses and clears busy.
// Assumes: inputs are already synchronized and filtered.
module i2cmon_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic sda_f,
    input  logic scl_f,
    output logic start_pulse,
    output logic stop_pulse,
    output logic bus_busy
);
    logic sda_d, scl_d;
    logic start_det, stop_det;

    // Condition decode from the current and previous filtered levels
    always_comb begin
        start_det = enable && scl_f && scl_d && sda_d && !sda_f;
        stop_det  = enable && scl_f && scl_d && !sda_d && sda_f;
    end

    // Previous-cycle copies of the filtered lines
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_d <= 1'b1;
            scl_d <= 1'b1;
        end else begin
            sda_d <= sda_f;
            scl_d <= scl_f;
        end
    end

    // Registered pulses and busy level; enable and STOP take priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_pulse <= 1'b0;
            stop_pulse  <= 1'b0;
            bus_busy    <= 1'b0;
        end else begin
            start_pulse <= start_det;
            stop_pulse  <= stop_det;
            if (!enable || stop_det) bus_busy <= 1'b0;
            else if (start_det)      bus_busy <= 1'b1;
        end
    end
endmodule

// File: rtl/i2cmon_low_timer.sv
// Module: SCL low-time counter with a programmable limit.
// Counts the edges on which SCL is low, clears while SCL is high or the block
// is disabled, and pulses once per low period when the count reaches the limit.
// Assumes: limit 0 means the check is off.
module i2cmon_low_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          scl_f,
    input  logic [TW-1:0] limit,
    output logic          timeout_pulse
);
    localparam int CW = TW + 1;

    logic [CW-1:0] low_cnt;
    logic          fired;
    logic          hit;

    // Limit reached during this low period and not yet reported
    always_comb hit = (limit != '0) && !fired && (low_cnt >= {1'b0, limit});

    // Saturating low-time count with a one-shot report
    always_ff @(posedge clk) begin
        if (!rst_n || !enable || scl_f) begin
            low_cnt       <= '0;
            fired         <= 1'b0;
            timeout_pulse <= 1'b0;
        end else begin
            timeout_pulse <= hit;
            if (hit)           fired   <= 1'b1;
            if (low_cnt != '1) low_cnt <= low_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_bus_monitor.sv
// Module: top of the I2C bus activity and timeout monitor.
// Conditions both wires, then feeds the condition detector and the low timer.
// Assumes: synchronous active-low reset; raw wires idle high.
module i2c_bus_monitor #(
    parameter int FILT_CYC = 3,
    parameter int TW       = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [TW-1:0] timeout_limit,
    input  logic          sda_in,
    input  logic          scl_in,
    output logic          start_pulse,
    output logic          stop_pulse,
    output logic          scl_level,
    output logic          bus_busy,
    output logic          timeout_pulse
);
    import i2cmon_pkg::*;

    logic [NUM_LINES-1:0] raw_lines;
    logic [NUM_LINES-1:0] filt_lines;
    bus_lines_t           bus_f;

    // Gather the raw wires into one vector for the conditioner array
    always_comb begin
        raw_lines           = '0;
        raw_lines[LINE_SDA] = sda_in;
        raw_lines[LINE_SCL] = scl_in;
    end

    // One conditioner per bus wire
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        i2cmon_line_filter #(
            .FILT_CYC  (FILT_CYC),
            .RESET_VAL (1'b1)
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw_lines[g]),
            .level (filt_lines[g])
        );
    end

    // Name the filtered levels
    always_comb begin
        bus_f.sda = filt_lines[LINE_SDA];
        bus_f.scl = filt_lines[LINE_SCL];
    end

    assign scl_level = bus_f.scl;

    i2cmon_cond_detect u_det (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .sda_f       (bus_f.sda),
        .scl_f       (bus_f.scl),
        .start_pulse (start_pulse),
        .stop_pulse  (stop_pulse),
        .bus_busy    (bus_busy)
    );

    i2cmon_low_timer #(
        .TW (TW)
    ) u_tmr (
        .clk           (clk),
        .rst_n         (rst_n),
        .enable        (enable),
        .scl_f         (bus_f.scl),
        .limit         (timeout_limit),
        .timeout_pulse (timeout_pulse)
    );
endmodule

// File: rtl/i2c_bus_monitor_checker.sv
// Module: property checker for the I2C bus monitor, bound to the top.
// Assumes: observes top-level ports only.
module i2c_bus_monitor_checker #(
    parameter int TW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable,
    input logic [TW-1:0] timeout_limit,
    input logic          start_pulse,
    input logic          stop_pulse,
    input logic          scl_level,
    input logic          bus_busy,
    input logic          timeout_pulse
);
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse); // R3
    AST_STOP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |=> !stop_pulse); // R4
    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> bus_busy); // R5
    AST_IDLE_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |-> !bus_busy); // R6
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!bus_busy && !start_pulse && !stop_pulse && !timeout_pulse)); // R7
    AST_TIMEOUT_WHILE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |-> !$past(scl_level)); // R8
    AST_TIMEOUT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_pulse |=> !timeout_pulse); // R9
    AST_ZERO_LIMIT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(timeout_limit) == '0) |-> !timeout_pulse); // R10
endmodule

bind i2c_bus_monitor i2c_bus_monitor_checker #(.TW(TW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .timeout_limit (timeout_limit),
    .start_pulse   (start_pulse),
    .stop_pulse    (stop_pulse),
    .scl_level     (scl_level),
    .bus_busy      (bus_busy),
    .timeout_pulse (timeout_pulse)
);

// File: tb/i2c_bus_monitor_tb.sv
module i2c_bus_monitor_tb;
    localparam int CLK_PERIOD = 10;
    localparam int FILT       = 3;
    localparam int TWB        = 16;
    localparam int CMAX       = (1 << (TWB + 1)) - 1;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           enable = 1'b0;
    logic [TWB-1:0] limit = 16'd20;
    logic           sda = 1'b1;
    logic           scl = 1'b1;
    logic           start_pulse, stop_pulse, scl_level, bus_busy, timeout_pulse;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit monitor_on = 1'b0;

    // Tallies gathered by the monitor
    int t_start = 0, t_stop = 0, t_to = 0, t_scl_low = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_bus_monitor #(.FILT_CYC(FILT), .TW(TWB)) u_dut (
        .clk (clk), .rst_n (rst_n), .enable (enable), .timeout_limit (limit),
        .sda_in (sda), .scl_in (scl),
        .start_pulse (start_pulse), .stop_pulse (stop_pulse),
        .scl_level (scl_level), .bus_busy (bus_busy), .timeout_pulse (timeout_pulse)
    );

    // Behavioural reference state
    int m_s1[2], m_s2[2], m_f[2], m_fc[2];
    int m_dsda, m_dscl, m_start, m_stop, m_busy, m_cnt, m_fired, m_to;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Reference model, advanced on each rising edge (index 0 = SDA, 1 = SCL)
    always @(posedge clk) begin
        int st, sp, raw[2];
        cycles++;
        raw[0] = sda; raw[1] = scl;
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_s1[i] = 1; m_s2[i] = 1; m_f[i] = 1; m_fc[i] = 0;
            end
            m_dsda = 1; m_dscl = 1; m_start = 0; m_stop = 0;
            m_busy = 0; m_cnt = 0; m_fired = 0; m_to = 0;
        end else begin
            st = (enable && m_f[1] && m_dscl && m_dsda && !m_f[0]) ? 1 : 0;
            sp = (enable && m_f[1] && m_dscl && !m_dsda && m_f[0]) ? 1 : 0;
            if (!enable || m_f[1]) begin
                m_cnt = 0; m_fired = 0; m_to = 0;
            end else begin
                m_to = (limit != 0 && !m_fired && m_cnt >= int'(limit)) ? 1 : 0;
                if (m_to) m_fired = 1;
                if (m_cnt < CMAX) m_cnt++;
            end
            if (!enable || sp) m_busy = 0;
            else if (st)       m_busy = 1;
            m_start = st; m_stop = sp;
            m_dsda = m_f[0]; m_dscl = m_f[1];
            for (int i = 0; i < 2; i++) begin
                if (m_s2[i] == m_f[i]) m_fc[i] = 0;
                else if (m_fc[i] == FILT - 1) begin m_f[i] = m_s2[i]; m_fc[i] = 0; end
                else m_fc[i]++;
                m_s2[i] = m_s1[i];
                m_s1[i] = raw[i];
            end
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (monitor_on) begin
            check(start_pulse == m_start[0], "R3 start_pulse", start_pulse, m_start);
            check(stop_pulse == m_stop[0], "R4 stop_pulse", stop_pulse, m_stop);
            check(bus_busy == m_busy[0], "R5/R6/R7 bus_busy", bus_busy, m_busy);
            check(scl_level == m_f[1][0], "R1/R2 scl_level", scl_level, m_f[1]);
            check(timeout_pulse == m_to[0], "R8 timeout_pulse", timeout_pulse, m_to);
            t_start += start_pulse; t_stop += stop_pulse;
            t_to += timeout_pulse; t_scl_low += !scl_level;
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_tallies();
        t_start = 0; t_stop = 0; t_to = 0; t_scl_low = 0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        wait_n(100000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        wait_n(3);
        monitor_on = 1'b1;
        // R11: reset values
        check(start_pulse == 0 && stop_pulse == 0 && bus_busy == 0 && timeout_pulse == 0,
              "R11 pulses/busy in reset", {start_pulse, stop_pulse, bus_busy, timeout_pulse}, 0);
        check(scl_level == 1, "R11 scl_level in reset", scl_level, 1);
        rst_n = 1'b1; enable = 1'b1;
        wait_n(10);

        // START, data bits, repeated START, STOP
        clear_tallies();
        sda = 0; wait_n(8);
        scl = 0; wait_n(8);
        for (int i = 0; i < 4; i++) begin
            sda = i[0]; wait_n(4);
            scl = 1; wait_n(8);
            scl = 0; wait_n(8);
        end
        sda = 1; wait_n(8);
        scl = 1; wait_n(8);
        sda = 0; wait_n(8);
        check(bus_busy == 1, "R5 busy after repeated START", bus_busy, 1);
        scl = 0; wait_n(8);
        sda = 0; wait_n(4);
        scl = 1; wait_n(8);
        sda = 1; wait_n(10);
        check(t_start == 2, "R3 START count incl. repeated", t_start, 2);
        check(t_stop == 1, "R4 STOP count", t_stop, 1);
        check(bus_busy == 0, "R6 busy after STOP", bus_busy, 0);

        // Glitches shorter than the filter must be ignored
        clear_tallies();
        scl = 0; wait_n(1); scl = 1; wait_n(6);
        sda = 0; wait_n(2); sda = 1; wait_n(6);
        scl = 0; wait_n(2); scl = 1; wait_n(8);
        check(t_scl_low == 0, "R1 SCL glitch filtered", t_scl_low, 0);
        check(t_start == 0 && t_stop == 0, "R1 SDA glitch gives no condition", t_start + t_stop, 0);

        // Timeout: one pulse per low period, counter clears when SCL high
        clear_tallies();
        sda = 0; wait_n(8);
        scl = 0; wait_n(60);
        check(t_to == 1, "R9 one timeout per low period", t_to, 1);
        scl = 1; wait_n(8);
        scl = 0; wait_n(60);
        check(t_to == 2, "R9 timer restarts after SCL high", t_to, 2);
        scl = 1; wait_n(8);
        scl = 0; wait_n(15);
        scl = 1; wait_n(8);
        check(t_to == 2, "R8 short low period no timeout", t_to, 2);

        // Limit zero disables the timeout
        limit = 16'd0;
        scl = 0; wait_n(60);
        check(t_to == 2, "R10 limit 0 disables timeout", t_to, 2);
        scl = 1; wait_n(8);
        limit = 16'd20;

        // Disable while busy
        check(bus_busy == 1, "R5 busy before disable", bus_busy, 1);
        enable = 0; wait_n(3);
        check(bus_busy == 0, "R7 busy cleared by disable", bus_busy, 0);
        sda = 1; wait_n(10);
        check(t_stop == 0, "R7 no STOP while disabled", t_stop, 0);
        enable = 1; wait_n(5);

        // Enable falling around the STOP registering edge (sweep)
        for (int off = 2; off <= 8; off++) begin
            sda = 0; wait_n(8);
            scl = 0; wait_n(8);
            scl = 1; wait_n(8);
            sda = 1; wait_n(off);
            enable = 0; wait_n(4);
            check(bus_busy == 0, "R7 busy low after disable", bus_busy, 0);
            enable = 1; wait_n(8);
        end

        monitor_on = 1'b0;
        wait_n(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule